// File: doc/BRIEF.md
# USB Type-C CC Attach Detection Controller

This block watches the status of the two configuration-channel (CC) lines of a USB Type-C port and decides whether something is plugged in, which way round the plug sits, and what the port should be. It takes a 6-bit status word and drives the attach state, plug orientation, data and power role, the VBUS source and sink enables, the VCONN enable, a SuperSpeed lane select, the terminations requested on each CC line, dual-role toggling and a one-cycle look-for-connection command. It also tracks a forced VBUS discharge that an external low-voltage alarm releases.

The controller acts only in the cycle after the status word differs from the value it last saw. Each such change is sorted into one of five cases: detach, source attach, sink attach, audio-detached or unknown. The case then updates the registered outputs. Debounce, analog comparators and Power Delivery messaging belong to neighbouring blocks.

Top module: `tcc_attach_ctrl`

## Requirements
- R1: While reset is asserted, and after it, the outputs take these values: attached 0, orientation CC1 (orient_cc2 0, ss_sel 1), data_host 0, power_source 0, both VBUS enables 0, vconn_en 0, drp_en 1, both role codes at the idle termination, look_cmd 0, discharge 0, cc_error 0.
- R2: The status word holds CC1 in bits 1:0, CC2 in bits 3:2, the termination flag in bit 4 and the toggling flag in bit 5. When the flag is 1 (presenting Rd), line codes 1, 2 and 3 read as Rp at default, 1.5 A and 3.0 A. When it is 0 (presenting Rp), codes 1 and 2 read as Ra and Rd. Every other code reads as open.
- R3: Outputs update only in the clock cycle after the status word differs from its previous value. Any bit counts as a change, the toggling flag included.
- R4: When exactly one line reads Rd, the port attaches as a source: attached 1, data_host 1, power_source 1, vbus_src_en 1, vbus_snk_en 0. The orientation is CC2 unless CC1 is the Rd line.
- R5: In a source attach, vconn_en is 1 only when the line that is not Rd reads Ra.
- R6: When one line reads any Rp level and the other reads open, the port attaches as a sink: attached 1, data_host 0, power_source 0, both VBUS enables 0, vconn_en 0, drp_en 0. The active line's role code becomes Rd (2) and the other line's becomes open (3). The orientation is the active line.
- R7: When both lines read open, the port detaches. attached, data_host, power_source, both VBUS enables and vconn_en go to 0, and the orientation returns to CC1. drp_en goes to 1 and both role codes go to the idle termination. look_cmd is 1 for exactly one cycle.
- R8: Orientation CC2 gives orient_cc2 1 and ss_sel 0. Orientation CC1 gives orient_cc2 0 and ss_sel 1.
- R9: One line at Ra with the other open (audio-detached) changes no output and leaves cc_error at 0.
- R10: Any other line combination sets cc_error to 1 and leaves every other output unchanged. The next change that falls into another case clears cc_error.
- R11: discharge goes to 1 on a detach or a sink attach. It goes to 0 on a source attach, or in the cycle after low_alarm is 1. If low_alarm is 1 in the same cycle as a detach or a sink attach, the detach or sink attach wins.
- R12: The idle termination is Rp (role code 1) when PREFER_SOURCE is 1 and Rd (role code 2) otherwise. Role codes are Ra 0, Rp 1, Rd 2, open 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cc_status | input | 6 | CC status word (layout in R2) |
| low_alarm | input | 1 | VBUS low-voltage alarm, releases discharge |
| attached | output | 1 | A partner is attached |
| orient_cc2 | output | 1 | 1 when the plug is oriented on CC2 |
| ss_sel | output | 1 | SuperSpeed lane select, high for CC1 |
| data_host | output | 1 | Data role is host |
| power_source | output | 1 | Power role is source |
| vbus_src_en | output | 1 | Source VBUS |
| vbus_snk_en | output | 1 | Sink VBUS |
| vconn_en | output | 1 | Supply VCONN |
| drp_en | output | 1 | Dual-role toggling enabled |
| role_cc1 | output | 2 | Termination requested on CC1 |
| role_cc2 | output | 2 | Termination requested on CC2 |
| look_cmd | output | 1 | One-cycle look-for-connection command |
| discharge | output | 1 | Forced VBUS discharge active |
| cc_error | output | 1 | Last change was an unknown combination |

## Verification
The assertions check the following on every cycle:
- A source never also sinks VBUS.
- VCONN is on only while VBUS is sourced.
- A sink always requests one Rd and one open termination, with toggling off.
- The lane select is always the inverse of the orientation.
- Nothing moves while the status word holds still.
- An error leaves the outputs in place.
- Discharge is never active while VBUS is sourced.

The bench scenarios show the parts no single-cycle property can express:
- The actual decoding of each line code under both termination flags.
- Which line wins the orientation.
- The exact Ra/Rd pairing that enables VCONN.
- That a status change in the toggling flag alone re-applies the same state.
- The set-over-alarm priority of the discharge latch.

// File: rtl/tcc_pkg.sv
// Package: shared types and constants for the Type-C attach controller.
// Assumes a status word with two 2-bit line fields, a termination flag
// and a toggling flag, in the positions given below.
package tcc_pkg;

    localparam int CC_W       = 2;
    localparam int NUM_LINES  = 2;
    localparam int TERM_BIT   = NUM_LINES * CC_W;
    localparam int TOGGLE_BIT = TERM_BIT + 1;
    localparam int STAT_W     = TOGGLE_BIT + 1;

    // Termination request codes driven to the port's CC terminations
    localparam logic [CC_W-1:0] TERM_RA   = 2'd0;
    localparam logic [CC_W-1:0] TERM_RP   = 2'd1;
    localparam logic [CC_W-1:0] TERM_RD   = 2'd2;
    localparam logic [CC_W-1:0] TERM_OPEN = 2'd3;

    // What the far end looks like on one line
    typedef enum logic [2:0] {
        LN_OPEN,
        LN_RA,
        LN_RD,
        LN_RP_DEF,
        LN_RP_1A5,
        LN_RP_3A0
    } line_e;

    // Outcome of classifying one status change
    typedef enum logic [2:0] {
        EV_DETACH,
        EV_SOURCE,
        EV_SINK,
        EV_AUDIO,
        EV_UNKNOWN
    } event_e;

    function automatic logic is_rp(line_e l);
        return (l == LN_RP_DEF) || (l == LN_RP_1A5) || (l == LN_RP_3A0);
    endfunction

endpackage

// File: rtl/tcc_line_decode.sv
// Module: tcc_line_decode
// Turns one 2-bit line code into a line class. The meaning of the code
// depends on which termination the port is presenting at that moment.
// Assumes term_rd = 1 while the port presents Rd. Purely combinational.
module tcc_line_decode
    import tcc_pkg::*;
(
    input  logic [CC_W-1:0] code,
    input  logic            term_rd,
    output line_e           cls
);

    // Map the code through the termination-dependent table
    always_comb begin
        cls = LN_OPEN;
        if (term_rd) begin
            case (code)
                2'd1:    cls = LN_RP_DEF;
                2'd2:    cls = LN_RP_1A5;
                2'd3:    cls = LN_RP_3A0;
                default: cls = LN_OPEN;
            endcase
        end else begin
            case (code)
                2'd1:    cls = LN_RA;
                2'd2:    cls = LN_RD;
                default: cls = LN_OPEN;
            endcase
        end
    end

endmodule

// File: rtl/tcc_classify.sv
// Module: tcc_classify
// Sorts a pair of line classes into one event. It also gives the active
// line for orientation and whether VCONN is wanted.
// Priority: detach, source, sink, audio-detached, unknown. Combinational.
module tcc_classify
    import tcc_pkg::*;
(
    input  line_e  l1,
    input  line_e  l2,
    output event_e ev,
    output logic   active_cc2,
    output logic   want_vconn
);

    logic both_open;
    logic src_hit;
    logic snk_hit;
    logic aud_hit;

    // Detect each candidate combination
    always_comb begin
        both_open = (l1 == LN_OPEN) && (l2 == LN_OPEN);
        src_hit   = (l1 == LN_RD) != (l2 == LN_RD);
        snk_hit   = (is_rp(l1) && (l2 == LN_OPEN)) || (is_rp(l2) && (l1 == LN_OPEN));
        aud_hit   = ((l1 == LN_RA) && (l2 == LN_OPEN)) || ((l2 == LN_RA) && (l1 == LN_OPEN));
    end

    // Pick the event by priority and derive orientation and VCONN need
    always_comb begin
        ev         = EV_UNKNOWN;
        active_cc2 = 1'b0;
        want_vconn = 1'b0;
        if (both_open) begin
            ev = EV_DETACH;
        end else if (src_hit) begin
            ev         = EV_SOURCE;
            active_cc2 = (l1 != LN_RD);
            want_vconn = ((l1 == LN_RD) && (l2 == LN_RA)) || ((l2 == LN_RD) && (l1 == LN_RA));
        end else if (snk_hit) begin
            ev         = EV_SINK;
            active_cc2 = (l1 == LN_OPEN);
        end else if (aud_hit) begin
            ev = EV_AUDIO;
        end
    end

endmodule

// File: rtl/tcc_port_ctrl.sv
// Module: tcc_port_ctrl
// Holds the port state and applies the action for each status change.
// A change is any difference from the status sampled in the last cycle.
// Assumes ev, active_cc2 and want_vconn are decoded from cc_status in
// the same cycle.
module tcc_port_ctrl
    import tcc_pkg::*;
#(
    parameter bit PREFER_SOURCE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [STAT_W-1:0] cc_status,
    input  event_e          ev,
    input  logic            active_cc2,
    input  logic            want_vconn,
    output logic            attached,
    output logic            orient_cc2,
    output logic            ss_sel,
    output logic            data_host,
    output logic            power_source,
    output logic            vbus_src_en,
    output logic            vbus_snk_en,
    output logic            vconn_en,
    output logic            drp_en,
    output logic [CC_W-1:0] role_cc1,
    output logic [CC_W-1:0] role_cc2,
    output logic            look_cmd,
    output logic            cc_error,
    output logic            dis_start,
    output logic            dis_stop
);

    localparam logic [CC_W-1:0] IDLE_TERM = PREFER_SOURCE ? TERM_RP : TERM_RD;

    logic [STAT_W-1:0] prev_q;
    logic              react;

    // Flag a change of the status word and the discharge triggers it causes
    always_comb begin
        react     = (cc_status != prev_q);
        dis_start = react && ((ev == EV_DETACH) || (ev == EV_SINK));
        dis_stop  = react && (ev == EV_SOURCE);
    end

    // Apply the action for the classified change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q       <= '0;
            attached     <= 1'b0;
            orient_cc2   <= 1'b0;
            ss_sel       <= 1'b1;
            data_host    <= 1'b0;
            power_source <= 1'b0;
            vbus_src_en  <= 1'b0;
            vbus_snk_en  <= 1'b0;
            vconn_en     <= 1'b0;
            drp_en       <= 1'b1;
            role_cc1     <= IDLE_TERM;
            role_cc2     <= IDLE_TERM;
            look_cmd     <= 1'b0;
            cc_error     <= 1'b0;
        end else begin
            prev_q   <= cc_status;
            look_cmd <= 1'b0;
            if (react) begin
                cc_error <= 1'b0;
                case (ev)
                    EV_DETACH: begin
                        attached     <= 1'b0;
                        orient_cc2   <= 1'b0;
                        ss_sel       <= 1'b1;
                        data_host    <= 1'b0;
                        power_source <= 1'b0;
                        vbus_src_en  <= 1'b0;
                        vbus_snk_en  <= 1'b0;
                        vconn_en     <= 1'b0;
                        drp_en       <= 1'b1;
                        role_cc1     <= IDLE_TERM;
                        role_cc2     <= IDLE_TERM;
                        look_cmd     <= 1'b1;
                    end
                    EV_SOURCE: begin
                        attached     <= 1'b1;
                        orient_cc2   <= active_cc2;
                        ss_sel       <= ~active_cc2;
                        data_host    <= 1'b1;
                        power_source <= 1'b1;
                        vbus_src_en  <= 1'b1;
                        vbus_snk_en  <= 1'b0;
                        vconn_en     <= want_vconn;
                    end
                    EV_SINK: begin
                        attached     <= 1'b1;
                        orient_cc2   <= active_cc2;
                        ss_sel       <= ~active_cc2;
                        data_host    <= 1'b0;
                        power_source <= 1'b0;
                        vbus_src_en  <= 1'b0;
                        vbus_snk_en  <= 1'b0;
                        vconn_en     <= 1'b0;
                        drp_en       <= 1'b0;
                        role_cc1     <= active_cc2 ? TERM_OPEN : TERM_RD;
                        role_cc2     <= active_cc2 ? TERM_RD : TERM_OPEN;
                    end
                    EV_AUDIO: begin
                        cc_error <= 1'b0;
                    end
                    default: begin
                        cc_error <= 1'b1;
                    end
                endcase
            end
        end
    end

    // A source never sinks VBUS
    assert_source_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
        power_source |-> (vbus_src_en && !vbus_snk_en));

    // VCONN only alongside a sourced VBUS
    assert_vconn_needs_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vconn_en |-> vbus_src_en);

    // A sink requests Rd on one line and open on the other, toggling off
    assert_sink_terms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (attached && !power_source) |->
        (!drp_en && (((role_cc1 == TERM_RD) && (role_cc2 == TERM_OPEN)) ||
                     ((role_cc1 == TERM_OPEN) && (role_cc2 == TERM_RD)))));

    // The look command is only issued in the detached, toggling state
    assert_look_detached_R7: assert property (@(posedge clk) disable iff (!rst_n)
        look_cmd |-> (!attached && drp_en && !vconn_en));

    // The lane select is the inverse of the orientation
    assert_ss_follows_orient_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_sel != orient_cc2);

    // A steady status word moves nothing
    assert_hold_when_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(cc_status)) |=>
        ($stable(attached) && $stable(orient_cc2) && $stable(vbus_src_en) && !look_cmd));

    // An unknown combination leaves the port state in place
    assert_error_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cc_error |-> ($stable(attached) && $stable(orient_cc2) && $stable(vbus_src_en) &&
                      $stable(role_cc1) && $stable(role_cc2)));

endmodule

// File: rtl/tcc_discharge.sv
// Module: tcc_discharge
// Forced VBUS discharge latch. Set when both VBUS paths are switched off.
// Cleared by a source attach or by the low-voltage alarm. Setting has
// priority over clearing.
module tcc_discharge (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic low_alarm,
    output logic discharge
);

    // Track the discharge request with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            discharge <= 1'b0;
        end else if (start_i) begin
            discharge <= 1'b1;
        end else if (stop_i || low_alarm) begin
            discharge <= 1'b0;
        end
    end

    // The alarm releases an active discharge unless a new one starts
    assert_alarm_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (discharge && low_alarm && !start_i) |=> !discharge);

endmodule

// File: rtl/tcc_attach_ctrl.sv
// Module: tcc_attach_ctrl (top)
// Type-C attach detection: decodes both CC lines, classifies each status
// change and drives port state, orientation, power paths and discharge.
// Assumes cc_status is already debounced and synchronous to clk.
module tcc_attach_ctrl
    import tcc_pkg::*;
#(
    parameter bit PREFER_SOURCE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] cc_status,
    input  logic              low_alarm,
    output logic              attached,
    output logic              orient_cc2,
    output logic              ss_sel,
    output logic              data_host,
    output logic              power_source,
    output logic              vbus_src_en,
    output logic              vbus_snk_en,
    output logic              vconn_en,
    output logic              drp_en,
    output logic [CC_W-1:0]   role_cc1,
    output logic [CC_W-1:0]   role_cc2,
    output logic              look_cmd,
    output logic              discharge,
    output logic              cc_error
);

    line_e  line_cls [NUM_LINES];
    event_e ev;
    logic   active_cc2;
    logic   want_vconn;
    logic   dis_start;
    logic   dis_stop;

    // One decoder per CC line
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        tcc_line_decode u_dec (
            .code    (cc_status[i*CC_W +: CC_W]),
            .term_rd (cc_status[TERM_BIT]),
            .cls     (line_cls[i])
        );
    end

    tcc_classify u_cls (
        .l1         (line_cls[0]),
        .l2         (line_cls[1]),
        .ev         (ev),
        .active_cc2 (active_cc2),
        .want_vconn (want_vconn)
    );

    tcc_port_ctrl #(.PREFER_SOURCE(PREFER_SOURCE)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cc_status    (cc_status),
        .ev           (ev),
        .active_cc2   (active_cc2),
        .want_vconn   (want_vconn),
        .attached     (attached),
        .orient_cc2   (orient_cc2),
        .ss_sel       (ss_sel),
        .data_host    (data_host),
        .power_source (power_source),
        .vbus_src_en  (vbus_src_en),
        .vbus_snk_en  (vbus_snk_en),
        .vconn_en     (vconn_en),
        .drp_en       (drp_en),
        .role_cc1     (role_cc1),
        .role_cc2     (role_cc2),
        .look_cmd     (look_cmd),
        .cc_error     (cc_error),
        .dis_start    (dis_start),
        .dis_stop     (dis_stop)
    );

    tcc_discharge u_dis (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (dis_start),
        .stop_i    (dis_stop),
        .low_alarm (low_alarm),
        .discharge (discharge)
    );

    // Discharge never runs while VBUS is being sourced
    assert_discharge_src_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        discharge |-> !vbus_src_en);

endmodule

// File: tb/tcc_attach_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: a vector table walked step by step, then directed tests.
module tcc_attach_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cc_status = 6'h00;
    logic       low_alarm = 1'b0;
    logic       attached, orient_cc2, ss_sel, data_host, power_source;
    logic       vbus_src_en, vbus_snk_en, vconn_en, drp_en;
    logic [1:0] role_cc1, role_cc2;
    logic       look_cmd, discharge, cc_error;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tcc_attach_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cc_status(cc_status), .low_alarm(low_alarm),
        .attached(attached), .orient_cc2(orient_cc2), .ss_sel(ss_sel),
        .data_host(data_host), .power_source(power_source),
        .vbus_src_en(vbus_src_en), .vbus_snk_en(vbus_snk_en), .vconn_en(vconn_en),
        .drp_en(drp_en), .role_cc1(role_cc1), .role_cc2(role_cc2),
        .look_cmd(look_cmd), .discharge(discharge), .cc_error(cc_error)
    );

    // Expected vector: att orient ss host src vsrc vsnk vconn drp err dis look r1 r2
    localparam logic [15:0] E_IDLE   = 16'b0_0_1_0_0_0_0_0_1_0_0_0_01_01;
    localparam logic [15:0] E_DET    = 16'b0_0_1_0_0_0_0_0_1_0_1_1_01_01;
    localparam logic [15:0] E_SRC1   = 16'b1_0_1_1_1_1_0_0_1_0_0_0_01_01;
    localparam logic [15:0] E_SRC2VC = 16'b1_1_0_1_1_1_0_1_1_0_0_0_01_01;
    localparam logic [15:0] E_SNK1   = 16'b1_0_1_0_0_0_0_0_0_0_1_0_10_11;
    localparam logic [15:0] E_SNK2   = 16'b1_1_0_0_0_0_0_0_0_0_1_0_11_10;
    localparam logic [15:0] E_SRC2   = 16'b1_1_0_1_1_1_0_0_1_0_0_0_01_01;
    localparam logic [15:0] E_SRC2ER = 16'b1_1_0_1_1_1_0_0_1_1_0_0_01_01;
    localparam logic [15:0] E_DETER  = 16'b0_0_1_0_0_0_0_0_1_1_1_0_01_01;

    // Step table: {cc_status, expected, requirement tag}
    localparam int NSTEP = 18;
    localparam logic [25:0] STEPS [NSTEP] = '{
        {6'h00, E_IDLE,   4'd3},   // R3 same as reset value: no reaction
        {6'h02, E_SRC1,   4'd4},   // R4 CC1 Rd, source on CC1
        {6'h00, E_DET,    4'd7},   // R7 detach
        {6'h09, E_SRC2VC, 4'd5},   // R5 CC2 Rd + CC1 Ra, VCONN on, CC2
        {6'h00, E_DET,    4'd12},  // R12 detach re-arms with Rp on both lines
        {6'h13, E_SNK1,   4'd6},   // R6 Rp 3.0 on CC1, sink
        {6'h10, E_DET,    4'd7},   // R7 both open under Rd
        {6'h14, E_SNK2,   4'd8},   // R8 sink on CC2, lane select low
        {6'h34, E_SNK2,   4'd3},   // R3 toggle flag change re-applies same state
        {6'h00, E_DET,    4'd7},   // R7
        {6'h08, E_SRC2,   4'd8},   // R8 source on CC2
        {6'h01, E_SRC2,   4'd9},   // R9 Ra + open: no change
        {6'h0A, E_SRC2ER, 4'd10},  // R10 both Rd: error, state kept
        {6'h05, E_SRC2ER, 4'd10},  // R10 both Ra: error
        {6'h00, E_DET,    4'd7},   // R7 clears the error
        {6'h1B, E_DETER,  4'd10},  // R10 two Rp lines: error
        {6'h12, E_SNK1,   4'd2},   // R2 code 2 under Rd is Rp 1.5
        {6'h03, E_DET,    4'd2}    // R2 code 3 under Rp is open
    };

    function automatic logic [15:0] observe();
        return {attached, orient_cc2, ss_sel, data_host, power_source, vbus_src_en,
                vbus_snk_en, vconn_en, drp_en, cc_error, discharge, look_cmd,
                role_cc1, role_cc2};
    endfunction

    task automatic check_vec(input int tag, input logic [15:0] exp);
        logic [15:0] got;
        got = observe();
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL R%0d: outputs got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic check_bit(input int tag, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL R%0d: %s got %b expected %b", tag, what, got, exp);
        end
    endtask

    task automatic step(input logic [5:0] cc, input logic alarm);
        @(negedge clk);
        cc_status = cc;
        low_alarm = alarm;
        @(posedge clk);
        @(negedge clk);
        low_alarm = 1'b0;
    endtask

    // Main stimulus
    initial begin
        // R1 reset state, sampled while reset is held
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_vec(1, E_IDLE);
        rst_n = 1'b1;
        @(negedge clk);
        check_vec(1, E_IDLE);

        for (int i = 0; i < NSTEP; i++) begin
            step(STEPS[i][25:20], 1'b0);
            check_vec(int'(STEPS[i][3:0]), STEPS[i][19:4]);
        end

        // R7 look command lasts one cycle
        @(negedge clk);
        check_bit(7, "look_cmd after one cycle", look_cmd, 1'b0);
        check_bit(11, "discharge held", discharge, 1'b1);

        // R11 alarm releases discharge
        step(6'h03, 1'b1);
        check_bit(11, "discharge after alarm", discharge, 1'b0);

        // R11 sink attach with alarm in the same cycle: set wins
        step(6'h13, 1'b1);
        check_bit(11, "discharge set over alarm", discharge, 1'b1);
        check_vec(6, E_SNK1);

        // R10 error from the sink state keeps the sink terminations
        step(6'h1F, 1'b0);
        check_bit(10, "cc_error", cc_error, 1'b1);
        check_bit(10, "attached kept", attached, 1'b1);
        check_bit(10, "role_cc1 kept", role_cc1[1], 1'b1);

        // R1 reset in mid-run returns to the idle state
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_vec(1, E_IDLE);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule